// File: doc/BRIEF.md
# Countdown Timer with Register Interface

A 32-bit down-counter reached through a small word-addressed register bus. Software loads a reload value, starts or stops counting with command bits written into the control word, and picks between a single pass and free-running operation that reloads itself. When the count runs out, a sticky timeout flag is raised. Software can watch it through the status word, clear it with any write to status, and route it to a level-sensitive interrupt pin through an enable bit.

The bus is a single-cycle interface. A request is a cycle with `bus_valid` high. `bus_write` selects a store or a load, and read data appears on `bus_rdata` one clock later, where it stays until the next read. The live count can be sampled at any time through a read-only snapshot word. Offsets that are not mapped read as zero and ignore stores.

Top module: `countdown_timer`

## Requirements
- R1: After reset, every register (status 0x0, control 0x4, period 0x8, snapshot 0xC) reads zero, the counter is halted and `irq` is low.
- R2: A store to period (0x8) keeps the value for read-back and loads the same value into the counter on the same clock edge.
- R3: While running (status bit 1 set), the counter drops by one on each clock; a load returns the count held in the clock cycle in which the load is sampled.
- R4: When a running counter holds 1 (or 0), the next edge is an expiry: status bit 0 (timeout) is set; in single-pass mode (control bit 1 clear) the counter goes to 0 and status bit 1 clears.
- R5: On expiry with control bit 1 set, the counter reloads from period and stays running.
- R6: Starting with a period of 0 expires on the first edge after the start edge.
- R7: Control bit 2 starts counting and control bit 3 stops it, with the count held; when both are set in one store, stop wins.
- R8: Any store to status (0x0) clears the timeout flag whatever the data; if an expiry falls on the same edge, the flag ends up set.
- R9: `irq` is high exactly when the timeout flag and control bit 0 (interrupt enable) are both set, and follows them from the edge that changed them.
- R10: Stores to snapshot (0xC) and to any unmapped offset (address bits [1:0] non-zero) change nothing; loads from unmapped offsets return zero.
- R11: Control reads back bits [3:0] as last stored, all other bits zero; read data is registered.
- R12: A store to period while running replaces the count on that edge and suppresses any expiry on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request in this cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | DATA_W | Store data |
| bus_rdata | output | DATA_W | Registered load data |
| irq | output | 1 | Level interrupt |

## Verification
Three functions can land on the same edge: a store to status can coincide with an expiry, and a store to period can coincide with the final count step. The bench times a status store so that it is sampled on the exact expiry edge and expects the flag to stay set. It also stores a new period while the counter runs and expects the next snapshot to return that value with no timeout. A reference model updated on every clock judges both cases, so a wrong priority shows up at once as a flag or count mismatch.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_PERIOD = 2'd2,
      SEL_SNAP   = 2'd3
   } cdt_sel_e;

   localparam int ST_FLAG_BIT  = 0;
   localparam int ST_RUN_BIT   = 1;
   localparam int CT_IE_BIT    = 0;
   localparam int CT_CONT_BIT  = 1;
   localparam int CT_START_BIT = 2;
   localparam int CT_STOP_BIT  = 3;
   localparam int CT_BITS      = 4;

   typedef struct packed {
      logic     wr_status;
      logic     wr_ctrl;
      logic     wr_period;
      logic     rd;
      logic     mapped;
      cdt_sel_e sel;
   } cdt_cmd_t;

endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
   import cdt_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output cdt_cmd_t          cmd
);

   logic upper_zero;

   generate
      if (ADDR_W < 4) begin : g_bad
         $error("cdt_decode: ADDR_W must be at least 4");
         assign upper_zero = 1'b0;
      end else if (ADDR_W > 4) begin : g_wide
         assign upper_zero = (addr[ADDR_W-1:4] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   logic access;

   always_comb begin
      cmd.mapped    = upper_zero && (addr[1:0] == 2'b00);
      cmd.sel       = cdt_sel_e'(addr[3:2]);
      access        = valid && write && cmd.mapped;
      cmd.wr_status = access && (cmd.sel == SEL_STATUS);
      cmd.wr_ctrl   = access && (cmd.sel == SEL_CTRL);
      cmd.wr_period = access && (cmd.sel == SEL_PERIOD);
      cmd.rd        = valid && !write;
   end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic [DATA_W-1:0] reload_val,
   input  logic              cont,
   input  logic              ctl_wr,
   input  logic              start_cmd,
   input  logic              stop_cmd,
   input  logic              clr_flag,
   output logic [DATA_W-1:0] count,
   output logic              running,
   output logic              flag
);

   generate
      if (DATA_W < 4) begin : g_bad
         $error("cdt_counter: DATA_W must be at least 4");
      end
   endgenerate

   logic              at_end;
   logic              expire;
   logic [DATA_W-1:0] count_d;
   logic              run_d;
   logic              flag_d;

   always_comb begin
      at_end = (count[DATA_W-1:1] == '0);
      expire = running && !load && at_end;

      if (load)
         count_d = load_val;
      else if (expire)
         count_d = cont ? reload_val : '0;
      else if (running)
         count_d = count - 1'b1;
      else
         count_d = count;

      run_d = running;
      if (expire && !cont)
         run_d = 1'b0;
      if (ctl_wr) begin
         if (stop_cmd)
            run_d = 1'b0;
         else if (start_cmd)
            run_d = 1'b1;
      end

      if (expire)
         flag_d = 1'b1;
      else if (clr_flag)
         flag_d = 1'b0;
      else
         flag_d = flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
         flag    <= 1'b0;
      end else begin
         count   <= count_d;
         running <= run_d;
         flag    <= flag_d;
      end
   end

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
   import cdt_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cdt_cmd_t          cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] count,
   input  logic              running,
   input  logic              flag,
   output logic [DATA_W-1:0] period,
   output logic              ie,
   output logic              cont,
   output logic              start_cmd,
   output logic              stop_cmd,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);

   localparam int PAD_CT = DATA_W - CT_BITS;
   localparam int PAD_ST = DATA_W - 2;

   logic [CT_BITS-1:0] ctl_q;
   logic [DATA_W-1:0]  mux;

   assign ie        = ctl_q[CT_IE_BIT];
   assign cont      = ctl_q[CT_CONT_BIT];
   assign start_cmd = wdata[CT_START_BIT];
   assign stop_cmd  = wdata[CT_STOP_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         period <= '0;
      end else begin
         if (cmd.wr_ctrl)
            ctl_q <= wdata[CT_BITS-1:0];
         if (cmd.wr_period)
            period <= wdata;
      end
   end

   always_comb begin
      mux = '0;
      if (cmd.mapped) begin
         unique case (cmd.sel)
            SEL_STATUS: mux = {{PAD_ST{1'b0}}, running, flag};
            SEL_CTRL:   mux = {{PAD_CT{1'b0}}, ctl_q};
            SEL_PERIOD: mux = period;
            SEL_SNAP:   mux = count;
            default:    mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (cmd.rd)
         rdata <= mux;
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= flag && ie;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = flag && ie;
      end
   endgenerate

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
   import cdt_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   cdt_cmd_t          cmd;
   logic [DATA_W-1:0] tmr_count;
   logic [DATA_W-1:0] tmr_period;
   logic              tmr_running;
   logic              tmr_flag;
   logic              tmr_ie;
   logic              tmr_cont;
   logic              start_cmd;
   logic              stop_cmd;

   cdt_decode #(.ADDR_W(ADDR_W)) u_decode (
      .valid (bus_valid),
      .write (bus_write),
      .addr  (bus_addr),
      .cmd   (cmd)
   );

   cdt_regs #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .wdata     (bus_wdata),
      .count     (tmr_count),
      .running   (tmr_running),
      .flag      (tmr_flag),
      .period    (tmr_period),
      .ie        (tmr_ie),
      .cont      (tmr_cont),
      .start_cmd (start_cmd),
      .stop_cmd  (stop_cmd),
      .rdata     (bus_rdata),
      .irq       (irq)
   );

   cdt_counter #(.DATA_W(DATA_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cmd.wr_period),
      .load_val   (bus_wdata),
      .reload_val (tmr_period),
      .cont       (tmr_cont),
      .ctl_wr     (cmd.wr_ctrl),
      .start_cmd  (start_cmd),
      .stop_cmd   (stop_cmd),
      .clr_flag   (cmd.wr_status),
      .count      (tmr_count),
      .running    (tmr_running),
      .flag       (tmr_flag)
   );

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq,
   input logic              flag,
   input logic              running,
   input logic [DATA_W-1:0] count,
   input logic              cont,
   input logic              ie
);

   logic st_wr, ct_wr, pd_wr;
   assign st_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(0));
   assign ct_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(4));
   assign pd_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(8));

   AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(pd_wr) |-> count == $past(bus_wdata)); // R2

   AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(running) && !$past(pd_wr) && $past(count) > 1
      |-> count == $past(count) - 1'b1); // R3

   AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(running) && $past(count) <= 1 && !$past(cont)
      && !$past(pd_wr) && !$past(ct_wr) |-> !running && flag && count == '0); // R4

   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(running) && !$past(pd_wr) |-> $stable(count)); // R7

   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(st_wr) && !$past(running) |-> !flag); // R8

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag && ie); // R9

endmodule

bind countdown_timer cdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .flag      (tmr_flag),
   .running   (tmr_running),
   .count     (tmr_count),
   .cont      (tmr_cont),
   .ie        (tmr_ie)
);

// File: tb/tb_countdown_timer.sv
module tb_countdown_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bv = 1'b0;
   logic        bw = 1'b0;
   logic [3:0]  ba = '0;
   logic [31:0] bd = '0;
   logic [31:0] rdata;
   logic        irq;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    chk_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   countdown_timer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bv),
      .bus_write (bw),
      .bus_addr  (ba),
      .bus_wdata (bd),
      .bus_rdata (rdata),
      .irq       (irq)
   );

   // behavioural reference model
   longint unsigned m_count, m_period;
   bit        m_flag, m_run, m_ie, m_cont;
   bit [3:0]  m_ctl;
   bit [31:0] m_rdata;

   always @(posedge clk or negedge rst_n) begin
      bit acc, wp, wc, ws, ex;
      int idx;
      if (!rst_n) begin
         m_count = 0; m_period = 0; m_flag = 0; m_run = 0;
         m_ie = 0; m_cont = 0; m_ctl = 0; m_rdata = 0;
      end else begin
         acc = bv && (ba[1:0] == 2'b00);
         idx = int'(ba[3:2]);
         ws  = acc && bw && idx == 0;
         wc  = acc && bw && idx == 1;
         wp  = acc && bw && idx == 2;
         if (bv && !bw) begin
            if (!acc) m_rdata = 0;
            else if (idx == 0) m_rdata = {30'd0, m_run, m_flag};
            else if (idx == 1) m_rdata = {28'd0, m_ctl};
            else if (idx == 2) m_rdata = 32'(m_period);
            else m_rdata = 32'(m_count);
         end
         ex = m_run && !wp && (m_count <= 1);
         if (ex) m_flag = 1;
         else if (ws) m_flag = 0;
         if (wp) m_count = longint'(bd);
         else if (ex) m_count = m_cont ? m_period : 0;
         else if (m_run) m_count = m_count - 1;
         if (ex && !m_cont) m_run = 0;
         if (wc) begin
            if (bd[3]) m_run = 0;
            else if (bd[2]) m_run = 1;
            m_ctl = bd[3:0];
            m_ie = bd[0];
            m_cont = bd[1];
         end
         if (wp) m_period = longint'(bd);
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         chk({cur_req, " rdata vs model"}, rdata, m_rdata);
         chk({cur_req, " R9 irq vs model"}, {31'd0, irq}, {31'd0, m_flag & m_ie});
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      bv = 1; bw = 1; ba = a; bd = d;
      @(posedge clk); #1;
      bv = 0; bw = 0; ba = '0; bd = '0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] q);
      bv = 1; bw = 0; ba = a;
      @(posedge clk); #1;
      q = rdata;
      bv = 0; ba = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] q, s;
      idle(3);
      chk_on = 1;
      chk("R1 rdata in reset", rdata, 32'd0);
      rst_n = 1;
      idle(1);
      // R1: reset values
      cur_req = "R1";
      for (int i = 0; i < 4; i++) begin
         rd(4'(i * 4), q);
         chk("R1 register after reset", q, 32'd0);
      end
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      // R2: period store and counter load
      cur_req = "R2";
      wr(4'h8, 32'h10);
      rd(4'h8, q); chk("R2 period readback", q, 32'h10);
      rd(4'hC, q); chk("R2 counter loaded", q, 32'h10);
      // R11: control readback
      cur_req = "R11";
      wr(4'h4, 32'hFFFF_FFF2);
      rd(4'h4, q); chk("R11 control low bits only", q, 32'h2);
      // R3: decrement per clock
      cur_req = "R3";
      wr(4'h8, 32'd20);
      wr(4'h4, 32'h5);
      rd(4'hC, q); chk("R3 snapshot first", q, 32'd20);
      rd(4'hC, q); chk("R3 snapshot next", q, 32'd19);
      rd(4'h0, q); chk("R3 running bit", q, 32'h2);
      // R4: single pass expiry
      cur_req = "R4";
      idle(30);
      rd(4'h0, q); chk("R4 flag set, stopped", q, 32'h1);
      rd(4'hC, q); chk("R4 count zero", q, 32'd0);
      chk("R9 irq with enable", {31'd0, irq}, 32'd1);
      // R8: clear with arbitrary data
      cur_req = "R8";
      wr(4'h0, 32'hDEAD_BEEF);
      rd(4'h0, q); chk("R8 flag cleared", q, 32'h0);
      // R5: continuous reload, interrupt disabled
      cur_req = "R5";
      wr(4'h8, 32'd3);
      wr(4'h4, 32'h6);
      idle(20);
      rd(4'h0, q); chk("R5 flag set and still running", q, 32'h3);
      chk("R9 irq masked", {31'd0, irq}, 32'd0);
      // R12: period store while running
      cur_req = "R12";
      wr(4'h8, 32'd100);
      rd(4'hC, q); chk("R12 count replaced", q, 32'd100);
      // R7: stop, hold, stop wins
      cur_req = "R7";
      wr(4'h4, 32'h8);
      rd(4'hC, s);
      idle(5);
      rd(4'hC, q); chk("R7 count held after stop", q, s);
      wr(4'h4, 32'h4);
      wr(4'h4, 32'hC);
      rd(4'h0, q); chk("R7 stop wins over start", q & 32'h2, 32'h0);
      // R10: ignored stores, unmapped loads
      cur_req = "R10";
      rd(4'hC, s);
      wr(4'hC, 32'h1234);
      rd(4'hC, q); chk("R10 snapshot store ignored", q, s);
      wr(4'h9, 32'h55);
      rd(4'h8, q); chk("R10 misaligned store ignored", q, 32'd100);
      rd(4'h9, q); chk("R10 unmapped load zero", q, 32'd0);
      // R6: zero period
      cur_req = "R6";
      wr(4'h0, 32'd0);
      wr(4'h8, 32'd0);
      wr(4'h4, 32'h4);
      rd(4'h0, q); chk("R6 running before expiry", q, 32'h2);
      rd(4'h0, q); chk("R6 expired next edge", q, 32'h1);
      // R8: clear on the expiry edge, set wins
      cur_req = "R8";
      wr(4'h0, 32'd0);
      wr(4'h8, 32'd2);
      wr(4'h4, 32'h5);
      idle(1);
      wr(4'h0, 32'd0);
      rd(4'h0, q); chk("R8 expiry beats clear", q, 32'h1);
      chk("R9 irq after collision", {31'd0, irq}, 32'd1);
      idle(2);
      finish_run();
   end

endmodule